// File: doc/BRIEF.md
# Temperature Alarm Window Comparator

This block watches a stream of signed temperature samples and keeps two status flags: one reporting that the temperature has climbed above a programmable upper boundary, the other reporting that it has fallen below a programmable lower boundary. Each flag turns on at its raw boundary compare. Once on, it turns off only after the temperature has moved back by a selectable hysteresis distance. This stops the flags from chattering when a slowly drifting temperature sits near a boundary. An event output is derived from the same two flags.

A simple write port loads a 16-bit configuration word and the two boundary registers. The configuration word carries a two-bit hysteresis selector. Two lock inputs, one for the critical trip and one for the alarm window, freeze that selector while either is high. Temperatures and boundaries are 13-bit two's complement values with a 0.0625 °C step. A sample is presented with a one-cycle valid strobe.

Top module: `temp_window_cmp`

## Requirements
- R1: Bits 15:11 of the configuration word always read as 0, whatever value was written there. Bits 8:0 store the written value.
- R2: Configuration bits 10:9 select the hysteresis: 00 gives 0 LSB, 01 gives 24 LSB (1.5 °C), 10 gives 48 LSB (3 °C) and 11 gives 96 LSB (6 °C). The configuration word resets to 0x0000.
- R3: On a strobed sample strictly greater than the upper boundary, the above flag becomes 1.
- R4: A set above flag becomes 0 on a strobed sample less than or equal to the upper boundary minus the hysteresis. Otherwise it keeps its value.
- R5: On a strobed sample greater than or equal to the lower boundary, the below flag becomes 0.
- R6: On a strobed sample less than or equal to the lower boundary minus the hysteresis (and below the lower boundary), the below flag becomes 1. A sample between the two thresholds leaves the flag unchanged.
- R7: The event output is the OR of the above flag and the below flag.
- R8: While crit_lock or win_lock is 1, a configuration write leaves bits 10:9 unchanged but still updates bits 8:0.
- R9: The flags and the event output reset to 0. They change only in the cycle after a sample strobe and hold while temp_valid is 0.
- R10: Threshold arithmetic does not wrap. With the upper boundary at -4090 and 96 LSB of hysteresis, a sample of -4096 does not clear a set above flag.
- R11: wr_sel 1 writes the upper boundary and wr_sel 2 writes the lower boundary, each taken from wr_data[12:0]. wr_sel 0 writes the configuration word and wr_sel 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 upper, 2 lower |
| wr_data | input | 16 | Write data |
| crit_lock | input | 1 | Critical-trip lock, freezes the hysteresis field |
| win_lock | input | 1 | Alarm-window lock, freezes the hysteresis field |
| temp_valid | input | 1 | Sample strobe |
| temp_in | input | 13 | Signed temperature sample, 0.0625 °C per LSB |
| cfg_word | output | 16 | Configuration readback |
| above_flag | output | 1 | Temperature above the window |
| below_flag | output | 1 | Temperature below the window |
| evt_out | output | 1 | Alarm event |

## Verification
The bench walks each hysteresis setting through the band between the set point and the release point. A design that releases at the raw boundary, or that uses the wrong offset, shows the wrong flag value at the exact release sample. At hysteresis 00, a sample equal to a boundary checks the priority between set and clear. A design that resolves it the wrong way leaves the below flag set at the lower boundary. Configuration writes with all bits set, made with and without each lock, show reserved bits that leak or a hysteresis field that moves while locked. A boundary near the most negative value catches threshold subtraction that wraps around at 13 bits.

// File: rtl/twc_pkg.sv
// Shared definitions for the temperature alarm window comparator.
// Assumes a 16-bit configuration word whose hysteresis field sits at 10:9.
package twc_pkg;
    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_LOWER = 2'd2,
        SEL_NONE  = 2'd3
    } wsel_e;

    localparam int CFG_W_DEF   = 16;
    localparam int HYST_LO_DEF = 9;
    localparam int RSVD_LO_DEF = 11;
    // hysteresis step in LSBs per doubling: 01 -> 24, 10 -> 48, 11 -> 96
    localparam int HYST_UNIT_DEF = 12;
endpackage

// File: rtl/twc_cfg_regs.sv
// Register file of the comparator: configuration word and two boundaries.
// Reserved configuration bits are forced to zero on write. The hysteresis
// field is frozen while either lock input is high. Assumes single-cycle writes.
module twc_cfg_regs
    import twc_pkg::*;
#(
    parameter int TEMP_W  = 13,
    parameter int CFG_W   = CFG_W_DEF,
    parameter int HYST_LO = HYST_LO_DEF,
    parameter int RSVD_LO = RSVD_LO_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              crit_lock,
    input  logic              win_lock,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [TEMP_W-1:0] upper_q,
    output logic [TEMP_W-1:0] lower_q
);
    localparam int HYST_HI = HYST_LO + 1;

    logic             locked;
    logic [CFG_W-1:0] cfg_next;

    assign locked = crit_lock | win_lock;

    // Purpose: form the value a config write stores (reserved cleared, lock honoured).
    always_comb begin
        cfg_next = wr_data;
        cfg_next[CFG_W-1:RSVD_LO] = '0;
        if (locked) begin
            cfg_next[HYST_HI:HYST_LO] = cfg_q[HYST_HI:HYST_LO];
        end
    end

    // Purpose: store configuration and boundaries on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            upper_q <= '0;
            lower_q <= '0;
        end else if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_CFG:   cfg_q   <= cfg_next;
                SEL_UPPER: upper_q <= wr_data[TEMP_W-1:0];
                SEL_LOWER: lower_q <= wr_data[TEMP_W-1:0];
                default:   ;
            endcase
        end
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[CFG_W-1:RSVD_LO] == '0);

    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CFG && (crit_lock || win_lock))
        |=> $stable(cfg_q[HYST_HI:HYST_LO]));

    assert_nosel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(cfg_q) && $stable(upper_q) && $stable(lower_q)));
endmodule

// File: rtl/twc_flag_unit.sv
// One hysteresis-qualified window flag. IS_ABOVE picks the variant:
// 1 = above flag (set on t > bound, clear on t <= bound - h),
// 0 = below flag (clear on t >= bound, set on t <= bound - h, clear wins).
// Assumes signed two's complement temperature and boundary values.
// Compares are done at TEMP_W+2 bits so that bound - h cannot wrap.
module twc_flag_unit #(
    parameter int TEMP_W    = 13,
    parameter int HYST_UNIT = 12,
    parameter bit IS_ABOVE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] bound,
    input  logic [1:0]        hyst_code,
    output logic              flag_q
);
    localparam int EXT_W = TEMP_W + 2;

    logic signed [EXT_W-1:0] t_x;
    logic signed [EXT_W-1:0] b_x;
    logic signed [EXT_W-1:0] h_x;
    logic signed [EXT_W-1:0] thr_x;
    logic                    flag_next;

    assign t_x   = {{2{temp[TEMP_W-1]}}, temp};
    assign b_x   = {{2{bound[TEMP_W-1]}}, bound};
    assign thr_x = b_x - h_x;

    // Purpose: decode the hysteresis selector into an offset in LSBs.
    always_comb begin
        case (hyst_code)
            2'd1:    h_x = EXT_W'(HYST_UNIT * 2);
            2'd2:    h_x = EXT_W'(HYST_UNIT * 4);
            2'd3:    h_x = EXT_W'(HYST_UNIT * 8);
            default: h_x = '0;
        endcase
    end

    generate
        if (IS_ABOVE) begin : g_above
            // Purpose: set on raw compare, release below threshold, else hold.
            always_comb begin
                if (t_x > b_x)          flag_next = 1'b1;
                else if (t_x <= thr_x)  flag_next = 1'b0;
                else                    flag_next = flag_q;
            end

            assert_above_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (temp_valid && $signed(temp) > $signed(bound)) |=> flag_q);
        end else begin : g_below
            // Purpose: clear on raw compare, set past threshold, else hold.
            always_comb begin
                if (t_x >= b_x)         flag_next = 1'b0;
                else if (t_x <= thr_x)  flag_next = 1'b1;
                else                    flag_next = flag_q;
            end

            assert_below_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (temp_valid && $signed(temp) >= $signed(bound)) |=> !flag_q);
        end
    endgenerate

    // Purpose: register the flag on each strobed sample.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (temp_valid) flag_q <= flag_next;
    end

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> $stable(flag_q));
endmodule

// File: rtl/temp_window_cmp.sv
// Top of the temperature alarm window comparator. Holds the register file,
// one above-window and one below-window flag unit, and the event output.
// Assumes one temperature sample per temp_valid strobe.
module temp_window_cmp
    import twc_pkg::*;
#(
    parameter int TEMP_W    = 13,
    parameter int CFG_W     = CFG_W_DEF,
    parameter int HYST_LO   = HYST_LO_DEF,
    parameter int RSVD_LO   = RSVD_LO_DEF,
    parameter int HYST_UNIT = HYST_UNIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              crit_lock,
    input  logic              win_lock,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_in,
    output logic [CFG_W-1:0]  cfg_word,
    output logic              above_flag,
    output logic              below_flag,
    output logic              evt_out
);
    localparam int HYST_HI = HYST_LO + 1;

    logic [TEMP_W-1:0] upper_q;
    logic [TEMP_W-1:0] lower_q;
    logic [1:0]        hyst_code;

    twc_cfg_regs #(
        .TEMP_W (TEMP_W),
        .CFG_W  (CFG_W),
        .HYST_LO(HYST_LO),
        .RSVD_LO(RSVD_LO)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .crit_lock(crit_lock),
        .win_lock (win_lock),
        .cfg_q    (cfg_word),
        .upper_q  (upper_q),
        .lower_q  (lower_q)
    );

    assign hyst_code = cfg_word[HYST_HI:HYST_LO];

    twc_flag_unit #(
        .TEMP_W   (TEMP_W),
        .HYST_UNIT(HYST_UNIT),
        .IS_ABOVE (1'b1)
    ) above_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_valid(temp_valid),
        .temp      (temp_in),
        .bound     (upper_q),
        .hyst_code (hyst_code),
        .flag_q    (above_flag)
    );

    twc_flag_unit #(
        .TEMP_W   (TEMP_W),
        .HYST_UNIT(HYST_UNIT),
        .IS_ABOVE (1'b0)
    ) below_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_valid(temp_valid),
        .temp      (temp_in),
        .bound     (lower_q),
        .hyst_code (hyst_code),
        .flag_q    (below_flag)
    );

    // Event follows the qualified window state of both flags.
    assign evt_out = above_flag | below_flag;

    assert_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out == (above_flag || below_flag));
endmodule

// File: tb/temp_window_cmp_tb_top.sv
// Scoreboard bench: the sample driver pushes expected flags into a queue and
// the monitor pops and compares them on the cycle after each strobe.
module temp_window_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = '0;
    logic        crit_lock = 1'b0;
    logic        win_lock = 1'b0;
    logic        temp_valid = 1'b0;
    logic [12:0] temp_in = '0;
    logic [15:0] cfg_word;
    logic        above_flag, below_flag, evt_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit    a;
        bit    b;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // bench model state
    int m_up = 0, m_lo = 0, m_h = 0;
    bit m_a = 0, m_b = 0;
    bit vld_d = 0;

    always #2.5 clk = ~clk;

    temp_window_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .crit_lock(crit_lock), .win_lock(win_lock), .temp_valid(temp_valid),
        .temp_in(temp_in), .cfg_word(cfg_word), .above_flag(above_flag),
        .below_flag(below_flag), .evt_out(evt_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int hyst_of(input int code);
        return (code == 0) ? 0 : (12 << code);
    endfunction

    task automatic do_write(input int sel, input int value);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(value);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic set_bound(input bit is_up, input int v);
        do_write(is_up ? 1 : 2, v & 16'h1FFF);
        if (is_up) m_up = v; else m_lo = v;
    endtask

    task automatic write_cfg(input int v, input int expect_word, input string tag);
        do_write(0, v);
        check(cfg_word == 16'(expect_word), tag, cfg_word, expect_word);
        m_h = hyst_of((expect_word >> 9) & 3);
    endtask

    // driver: apply one sample and push the model's expectation
    task automatic sample(input int t, input string tag);
        exp_t e;
        @(negedge clk);
        temp_valid = 1'b1; temp_in = 13'(t);
        if (t > m_up) m_a = 1;
        else if (t <= m_up - m_h) m_a = 0;
        if (t >= m_lo) m_b = 0;
        else if (t <= m_lo - m_h) m_b = 1;
        e.a = m_a; e.b = m_b; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    always @(posedge clk) vld_d <= temp_valid;

    // monitor: compare results one cycle after each strobe
    always @(negedge clk) begin
        if (vld_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(above_flag == e.a, {e.tag, " above"}, above_flag, e.a);
            check(below_flag == e.b, {e.tag, " below"}, below_flag, e.b);
            check(evt_out == (e.a | e.b), {"R7 evt ", e.tag}, evt_out, e.a | e.b);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_word == 16'h0000, "R2 reset cfg", cfg_word, 0);
        check({above_flag, below_flag, evt_out} == 3'b000, "R9 reset flags",
              {above_flag, below_flag, evt_out}, 0);

        set_bound(1, 800);
        set_bound(0, 160);
        write_cfg(16'hFFFF, 16'h07FF, "R1 reserved bits");
        do_write(3, 16'h0000);
        check(cfg_word == 16'h07FF, "R11 sel 3 no write", cfg_word, 16'h07FF);
        write_cfg(16'h0000, 16'h0000, "R2 hyst 00");

        // no hysteresis: raw compare
        sample(400, "R3 inside");
        sample(801, "R3 above set");
        sample(800, "R4 raw clear h0");
        sample(160, "R5 at lower h0");
        sample(159, "R6 below h0");
        sample(160, "R5 clear h0");

        // 3 C hysteresis
        write_cfg(16'h0400, 16'h0400, "R2 hyst 10");
        sample(801, "R3 set h48");
        sample(790, "R4 hold h48");
        sample(753, "R4 hold edge h48");
        sample(752, "R4 clear h48");
        sample(120, "R6 hold h48");
        sample(112, "R6 set h48");
        sample(150, "R6 hold set h48");
        sample(160, "R5 clear h48");

        // 1.5 C hysteresis
        write_cfg(16'h0200, 16'h0200, "R2 hyst 01");
        sample(801, "R3 set h24");
        sample(777, "R4 hold h24");
        sample(776, "R4 clear h24");

        // 6 C hysteresis
        write_cfg(16'h0600, 16'h0600, "R2 hyst 11");
        sample(801, "R3 set h96");
        sample(705, "R4 hold h96");
        sample(704, "R4 clear h96");
        sample(64, "R6 set h96");
        sample(159, "R6 hold h96");

        // idle: no strobe, outputs hold
        @(negedge clk);
        temp_in = 13'(2000);
        repeat (3) @(negedge clk);
        check({above_flag, below_flag} == 2'b01, "R9 hold idle",
              {above_flag, below_flag}, 1);

        // locks
        crit_lock = 1'b1;
        write_cfg(16'h0001, 16'h0601, "R8 crit lock");
        crit_lock = 1'b0; win_lock = 1'b1;
        write_cfg(16'h0200, 16'h0600, "R8 win lock");
        win_lock = 1'b0;
        write_cfg(16'h0200, 16'h0200, "R8 unlocked");

        // extended-width thresholds near the most negative value
        write_cfg(16'h0600, 16'h0600, "R2 hyst 11 again");
        set_bound(1, -4090);
        set_bound(0, -4096);
        sample(-4000, "R10 set near min");
        sample(-4096, "R10 no wrap hold");
        sample(-4096, "R5 at min lower");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule